// File: doc/BRIEF.md
# Skewed Two-Bank Cache Tag Controller with One-Move Relocation

This block holds the tag side of a two-bank cache in which each bank is indexed by its own hash of the block address. Bank 0 uses the low address bits as its index. Bank 1 uses those same bits XORed with the low bits of the tag. Two blocks that collide in one bank therefore usually land in different sets of the other bank. Each entry stores a valid bit, a tag and a small timestamp. A global allocation counter supplies the timestamps, and age is the distance from a timestamp back to the counter, taken modulo the counter range.

A lookup is presented for one cycle on `req_valid`/`req_addr`, and the result appears in the following cycle. A hit refreshes the timestamp of the block that was hit. On a miss the controller weighs four possible victims:

- the two direct occupants of the incoming block's sets;
- the block in bank 1 that the bank-0 occupant would displace if it moved to its own bank-1 set;
- the block in bank 0 that the bank-1 occupant would displace if it moved to its own bank-0 set.

It evicts the best of these four. In the same update it performs at most one move and installs the new tag. The evicted block, if any, is reported on `victim_valid`/`victim_addr`. Data storage, write buffering and the memory side belong to the surrounding cache.

Top module: `skw_reloc_ctrl`

## Requirements
- R1: After reset every entry is invalid, the allocation counter is 0 and all outputs are low, so the first lookup of any address misses and reports no victim.
- R2: A lookup whose tag is valid at index `addr[IDX_W-1:0]` of bank 0, or at the bank-1 index, raises `hit` for exactly the one cycle after the request, with `miss_done` low.
- R3: Any other lookup raises `miss_done` for exactly the one cycle after the request, with `hit` low, and the requested block is resident from then on, so a later lookup of it hits.
- R4: The bank-1 index is `addr[IDX_W-1:0] XOR tag[IDX_W-1:0]`, where the tag is `addr[ADDR_W-1:IDX_W]`. Two blocks that share a bank-0 index but differ in bank-1 index can therefore be resident at the same time.
- R5: If any of the four candidates is an invalid entry, an invalid one is taken. Then no block is evicted, `victim_valid` stays low, and every block that was resident before the miss stays resident.
- R6: Among valid candidates, the one with the largest age `(counter - timestamp) mod 2^TS_W` is evicted. Its block address is reported with `victim_valid` high in the same cycle as `miss_done`.
- R7: If the chosen candidate is one of the two displaced blocks, the corresponding direct occupant moves to its set in the other bank, keeps its timestamp and still hits afterwards. The new block is installed in the set that was vacated.
- R8: Ties in the selection key go to the bank-0 direct occupant first. Next comes the bank-1 direct occupant, then the block displaced by moving the bank-0 occupant, and last the block displaced by moving the bank-1 occupant.
- R9: Every miss installs the new block with the current counter value and then advances the counter by one. A hit writes the current counter value into the hit block's timestamp and leaves the counter unchanged.
- R10: Age is computed with wraparound, so selection stays correct after the counter has passed through its full range.
- R11: A cycle with `req_valid` low produces no `hit`, `miss_done` or `victim_valid` in the next cycle and changes no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Block address of the lookup |
| hit | output | 1 | Lookup found the block (one cycle after request) |
| miss_done | output | 1 | Lookup missed and the block was installed (one cycle after request) |
| victim_valid | output | 1 | A valid block was evicted by this miss |
| victim_addr | output | ADDR_W | Block address of the evicted block |

## Verification
The bench builds the controller with ADDR_W=8, IDX_W=2 and TS_W=3. That gives four sets per bank, a six-bit tag and a counter that wraps after eight installs. With only four sets, hand-built sequences can force each of the four candidate kinds, and the tie and invalid-first orderings become easy to hit. A short pseudo-random address stream over 32 blocks drives the counter through its wrap many times, which exposes age comparisons that straddle the wrap point. Every result is compared against an independent model of the requirements.

// File: rtl/skw_pkg.sv
package skw_pkg;

   localparam int NUM_CAND = 4;

   // candidate order doubles as tie priority
   typedef enum logic [1:0] {
      PICK_DIR0  = 2'd0,
      PICK_DIR1  = 2'd1,
      PICK_MOVE0 = 2'd2,
      PICK_MOVE1 = 2'd3
   } pick_e;

endpackage

// File: rtl/skw_remap.sv
// Maps a set index through the skew: index xor low tag bits.
module skw_remap #(
   parameter int IDX_W = 4
) (
   input  logic [IDX_W-1:0] idx_in,
   input  logic [IDX_W-1:0] tag_lo,
   output logic [IDX_W-1:0] idx_out
);
   assign idx_out = idx_in ^ tag_lo;
endmodule

// File: rtl/skw_bank.sv
// One bank of tag state: two combinational read ports, one write port.
module skw_bank #(
   parameter int IDX_W = 4,
   parameter int TAG_W = 12,
   parameter int TS_W  = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd_idx_a,
   output logic             rd_vld_a,
   output logic [TAG_W-1:0] rd_tag_a,
   output logic [TS_W-1:0]  rd_ts_a,
   input  logic [IDX_W-1:0] rd_idx_b,
   output logic             rd_vld_b,
   output logic [TAG_W-1:0] rd_tag_b,
   output logic [TS_W-1:0]  rd_ts_b,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [TS_W-1:0]  wr_ts
);
   localparam int DEPTH = 1 << IDX_W;

   logic             vld_q [DEPTH];
   logic [TAG_W-1:0] tag_q [DEPTH];
   logic [TS_W-1:0]  ts_q  [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < DEPTH; k++) begin
            vld_q[k] <= 1'b0;
            tag_q[k] <= '0;
            ts_q[k]  <= '0;
         end
      end else if (wr_en) begin
         vld_q[wr_idx] <= 1'b1;
         tag_q[wr_idx] <= wr_tag;
         ts_q[wr_idx]  <= wr_ts;
      end
   end

   assign rd_vld_a = vld_q[rd_idx_a];
   assign rd_tag_a = tag_q[rd_idx_a];
   assign rd_ts_a  = ts_q[rd_idx_a];
   assign rd_vld_b = vld_q[rd_idx_b];
   assign rd_tag_b = tag_q[rd_idx_b];
   assign rd_ts_b  = ts_q[rd_idx_b];
endmodule

// File: rtl/skw_pick.sv
// Chooses the victim among candidates: invalid first, then oldest, ties to lowest slot.
module skw_pick
   import skw_pkg::*;
#(
   parameter int TS_W = 5
) (
   input  logic [TS_W-1:0] now,
   input  logic            cand_vld [NUM_CAND],
   input  logic [TS_W-1:0] cand_ts  [NUM_CAND],
   output pick_e           sel
);
   localparam int KEY_W = TS_W + 1;

   logic [KEY_W-1:0] key [NUM_CAND];

   for (genvar g = 0; g < NUM_CAND; g++) begin : g_key
      logic [TS_W-1:0] age;
      assign age    = now - cand_ts[g];
      assign key[g] = {~cand_vld[g], age};
   end

   always_comb begin
      logic [KEY_W-1:0] best;
      best = key[0];
      sel  = PICK_DIR0;
      for (int k = 1; k < NUM_CAND; k++) begin
         if (key[k] > best) begin
            best = key[k];
            sel  = pick_e'(k);
         end
      end
   end
endmodule

// File: rtl/skw_reloc_ctrl.sv
module skw_reloc_ctrl
   import skw_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int IDX_W  = 4,
   parameter int TS_W   = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              hit,
   output logic              miss_done,
   output logic              victim_valid,
   output logic [ADDR_W-1:0] victim_addr
);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("skw_reloc_ctrl: IDX_W out of range");
   end
   if (TAG_W < IDX_W) begin : g_bad_tag
      $error("skw_reloc_ctrl: tag narrower than index, skew undefined");
   end
   if (TS_W < 2) begin : g_bad_ts
      $error("skw_reloc_ctrl: TS_W too small");
   end

   // request fields
   logic [TAG_W-1:0] rq_tag;
   logic [IDX_W-1:0] ix0, ix1;
   assign rq_tag = req_addr[ADDR_W-1:IDX_W];
   assign ix0    = req_addr[IDX_W-1:0];

   // bank read results
   logic             b0a_vld, b0b_vld, b1a_vld, b1b_vld;
   logic [TAG_W-1:0] b0a_tag, b0b_tag, b1a_tag, b1b_tag;
   logic [TS_W-1:0]  b0a_ts,  b0b_ts,  b1a_ts,  b1b_ts;
   logic [IDX_W-1:0] alt1;   // bank-1 set of the bank-0 occupant
   logic [IDX_W-1:0] alt0;   // bank-0 set of the bank-1 occupant
   logic [IDX_W-1:0] b1b_home;

   skw_remap #(.IDX_W(IDX_W)) i_map_req (
      .idx_in(ix0), .tag_lo(rq_tag[IDX_W-1:0]), .idx_out(ix1));
   skw_remap #(.IDX_W(IDX_W)) i_map_alt1 (
      .idx_in(ix0), .tag_lo(b0a_tag[IDX_W-1:0]), .idx_out(alt1));
   skw_remap #(.IDX_W(IDX_W)) i_map_alt0 (
      .idx_in(ix1), .tag_lo(b1a_tag[IDX_W-1:0]), .idx_out(alt0));
   skw_remap #(.IDX_W(IDX_W)) i_map_b1b (
      .idx_in(alt1), .tag_lo(b1b_tag[IDX_W-1:0]), .idx_out(b1b_home));

   // write controls
   logic             w0_en, w1_en;
   logic [IDX_W-1:0] w0_idx, w1_idx;
   logic [TAG_W-1:0] w0_tag, w1_tag;
   logic [TS_W-1:0]  w0_ts,  w1_ts;

   skw_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TS_W(TS_W)) i_bank0 (
      .clk(clk), .rst(rst),
      .rd_idx_a(ix0),  .rd_vld_a(b0a_vld), .rd_tag_a(b0a_tag), .rd_ts_a(b0a_ts),
      .rd_idx_b(alt0), .rd_vld_b(b0b_vld), .rd_tag_b(b0b_tag), .rd_ts_b(b0b_ts),
      .wr_en(w0_en), .wr_idx(w0_idx), .wr_tag(w0_tag), .wr_ts(w0_ts));

   skw_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TS_W(TS_W)) i_bank1 (
      .clk(clk), .rst(rst),
      .rd_idx_a(ix1),  .rd_vld_a(b1a_vld), .rd_tag_a(b1a_tag), .rd_ts_a(b1a_ts),
      .rd_idx_b(alt1), .rd_vld_b(b1b_vld), .rd_tag_b(b1b_tag), .rd_ts_b(b1b_ts),
      .wr_en(w1_en), .wr_idx(w1_idx), .wr_tag(w1_tag), .wr_ts(w1_ts));

   // lookup
   logic lk_hit0, lk_hit1, lk_hit;
   assign lk_hit0 = b0a_vld && (b0a_tag == rq_tag);
   assign lk_hit1 = b1a_vld && (b1a_tag == rq_tag);
   assign lk_hit  = lk_hit0 || lk_hit1;

   // allocation counter
   logic [TS_W-1:0] ts_cnt;

   // victim choice
   logic            c_vld [NUM_CAND];
   logic [TS_W-1:0] c_ts  [NUM_CAND];
   pick_e           pick;

   assign c_vld[PICK_DIR0]  = b0a_vld;
   assign c_ts[PICK_DIR0]   = b0a_ts;
   assign c_vld[PICK_DIR1]  = b1a_vld;
   assign c_ts[PICK_DIR1]   = b1a_ts;
   assign c_vld[PICK_MOVE0] = b1b_vld;
   assign c_ts[PICK_MOVE0]  = b1b_ts;
   assign c_vld[PICK_MOVE1] = b0b_vld;
   assign c_ts[PICK_MOVE1]  = b0b_ts;

   skw_pick #(.TS_W(TS_W)) i_pick (
      .now(ts_cnt), .cand_vld(c_vld), .cand_ts(c_ts), .sel(pick));

   // update decode
   logic              ev_vld;
   logic [ADDR_W-1:0] ev_addr;

   always_comb begin
      w0_en  = 1'b0;  w0_idx = ix0;  w0_tag = rq_tag;  w0_ts = ts_cnt;
      w1_en  = 1'b0;  w1_idx = ix1;  w1_tag = rq_tag;  w1_ts = ts_cnt;
      ev_vld = 1'b0;
      ev_addr = '0;
      if (req_valid) begin
         if (lk_hit0) begin
            w0_en = 1'b1;
         end else if (lk_hit1) begin
            w1_en = 1'b1;
         end else begin
            unique case (pick)
               PICK_DIR0: begin
                  w0_en   = 1'b1;
                  ev_vld  = b0a_vld;
                  ev_addr = {b0a_tag, ix0};
               end
               PICK_DIR1: begin
                  w1_en   = 1'b1;
                  ev_vld  = b1a_vld;
                  ev_addr = {b1a_tag, alt0};
               end
               PICK_MOVE0: begin
                  w0_en   = 1'b1;
                  w1_en   = 1'b1;
                  w1_idx  = alt1;
                  w1_tag  = b0a_tag;
                  w1_ts   = b0a_ts;
                  ev_vld  = b1b_vld;
                  ev_addr = {b1b_tag, b1b_home};
               end
               PICK_MOVE1: begin
                  w1_en   = 1'b1;
                  w0_en   = 1'b1;
                  w0_idx  = alt0;
                  w0_tag  = b1a_tag;
                  w0_ts   = b1a_ts;
                  ev_vld  = b0b_vld;
                  ev_addr = {b0b_tag, alt0};
               end
               default: ;
            endcase
         end
      end
   end

   // state and responses
   always_ff @(posedge clk) begin
      if (rst) begin
         ts_cnt       <= '0;
         hit          <= 1'b0;
         miss_done    <= 1'b0;
         victim_valid <= 1'b0;
         victim_addr  <= '0;
      end else begin
         hit          <= req_valid && lk_hit;
         miss_done    <= req_valid && !lk_hit;
         victim_valid <= ev_vld;
         victim_addr  <= ev_vld ? ev_addr : '0;
         if (req_valid && !lk_hit) ts_cnt <= ts_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/skw_reloc_ctrl_chk.sv
module skw_reloc_ctrl_chk #(
   parameter int TS_W = 5
) (
   input logic            clk,
   input logic            rst,
   input logic            req_valid,
   input logic            hit,
   input logic            miss_done,
   input logic            victim_valid,
   input logic            lk_hit,
   input logic [TS_W-1:0] ts_cnt,
   input logic            b0a_vld,
   input logic            b1a_vld
);
   // R2
   hit_after_lookup_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && lk_hit) |=> (hit && !miss_done));

   // R3
   miss_after_lookup_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !lk_hit) |=> (miss_done && !hit));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> (!hit && !miss_done && !victim_valid));

   // R6
   victim_only_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
      victim_valid |-> miss_done);

   // R5
   invalid_first_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !lk_hit && (!b0a_vld || !b1a_vld)) |=> !victim_valid);

   // R9
   cnt_hold_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
      (!req_valid || lk_hit) |=> $stable(ts_cnt));

   // R9
   cnt_step_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !lk_hit) |=> (ts_cnt == TS_W'($past(ts_cnt) + 1'b1)));
endmodule

bind skw_reloc_ctrl skw_reloc_ctrl_chk #(.TS_W(TS_W)) i_chk (
   .clk(clk), .rst(rst), .req_valid(req_valid), .hit(hit),
   .miss_done(miss_done), .victim_valid(victim_valid), .lk_hit(lk_hit),
   .ts_cnt(ts_cnt), .b0a_vld(b0a_vld), .b1a_vld(b1a_vld));

// File: tb/test_skw_reloc_ctrl.sv
module test_skw_reloc_ctrl;
   localparam int AW = 8;
   localparam int IW = 2;
   localparam int TW = 3;
   localparam int GW = AW - IW;
   localparam int DP = 1 << IW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          hit, miss_done, victim_valid;
   logic [AW-1:0] victim_addr;

   always #5 clk = ~clk;

   skw_reloc_ctrl #(.ADDR_W(AW), .IDX_W(IW), .TS_W(TW)) i_skw_reloc_ctrl (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
      .hit(hit), .miss_done(miss_done), .victim_valid(victim_valid),
      .victim_addr(victim_addr));

   int n_chk = 0;
   int n_fail = 0;

   // reference model state
   logic          m_v0 [DP], m_v1 [DP];
   logic [GW-1:0] m_t0 [DP], m_t1 [DP];
   logic [TW-1:0] m_s0 [DP], m_s1 [DP];
   logic [TW-1:0] m_cnt;

   // last observed outputs
   logic          l_hit, l_miss, l_vv;
   logic [AW-1:0] l_va;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int k = 0; k < DP; k++) begin
         m_v0[k] = 0; m_v1[k] = 0; m_t0[k] = '0; m_t1[k] = '0; m_s0[k] = '0; m_s1[k] = '0;
      end
      m_cnt = '0;
   endtask

   task automatic model_step(input logic [AW-1:0] a, output logic eh, output logic em,
                             output logic ev, output logic [AW-1:0] ea);
      logic [GW-1:0] t;
      logic [IW-1:0] i0, i1, p0, p1;
      logic          cv [4];
      logic [TW-1:0] cs [4];
      logic [GW-1:0] mt;
      logic [TW-1:0] ms;
      int            best, bk, sc;
      t  = a[AW-1:IW];
      i0 = a[IW-1:0];
      i1 = i0 ^ t[IW-1:0];
      eh = 0; em = 0; ev = 0; ea = '0;
      if (m_v0[i0] && m_t0[i0] == t) begin
         eh = 1; m_s0[i0] = m_cnt;
      end else if (m_v1[i1] && m_t1[i1] == t) begin
         eh = 1; m_s1[i1] = m_cnt;
      end else begin
         em = 1;
         p1 = i0 ^ m_t0[i0][IW-1:0];
         p0 = i1 ^ m_t1[i1][IW-1:0];
         cv[0] = m_v0[i0]; cs[0] = m_s0[i0];
         cv[1] = m_v1[i1]; cs[1] = m_s1[i1];
         cv[2] = m_v1[p1]; cs[2] = m_s1[p1];
         cv[3] = m_v0[p0]; cs[3] = m_s0[p0];
         best = -1; bk = 0;
         for (int k = 0; k < 4; k++) begin
            logic [TW-1:0] ag;
            ag = m_cnt - cs[k];
            sc = cv[k] ? int'(ag) : (1 << TW);
            if (sc > best) begin best = sc; bk = k; end
         end
         case (bk)
            0: begin
               ev = m_v0[i0]; ea = {m_t0[i0], i0};
               m_v0[i0] = 1; m_t0[i0] = t; m_s0[i0] = m_cnt;
            end
            1: begin
               ev = m_v1[i1]; ea = {m_t1[i1], i1 ^ m_t1[i1][IW-1:0]};
               m_v1[i1] = 1; m_t1[i1] = t; m_s1[i1] = m_cnt;
            end
            2: begin
               ev = m_v1[p1]; ea = {m_t1[p1], p1 ^ m_t1[p1][IW-1:0]};
               mt = m_t0[i0]; ms = m_s0[i0];
               m_v1[p1] = 1; m_t1[p1] = mt; m_s1[p1] = ms;
               m_v0[i0] = 1; m_t0[i0] = t; m_s0[i0] = m_cnt;
            end
            default: begin
               ev = m_v0[p0]; ea = {m_t0[p0], p0};
               mt = m_t1[i1]; ms = m_s1[i1];
               m_v0[p0] = 1; m_t0[p0] = mt; m_s0[p0] = ms;
               m_v1[i1] = 1; m_t1[i1] = t; m_s1[i1] = m_cnt;
            end
         endcase
         m_cnt = m_cnt + 1'b1;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; req_valid = 1'b0;
      repeat (3) @(negedge clk);
      model_clear();
      rst = 1'b0;
   endtask

   task automatic do_req(input logic [AW-1:0] a, input string vtag);
      logic eh, em, ev;
      logic [AW-1:0] ea;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      model_step(a, eh, em, ev, ea);
      @(negedge clk);
      req_valid = 1'b0;
      l_hit = hit; l_miss = miss_done; l_vv = victim_valid; l_va = victim_addr;
      chk(hit === eh, "R2", 32'(hit), 32'(eh));
      chk(miss_done === em, "R3", 32'(miss_done), 32'(em));
      chk(victim_valid === ev, vtag, 32'(victim_valid), 32'(ev));
      if (ev) chk(victim_addr === ea, vtag, 32'(victim_addr), 32'(ea));
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk);
      chk(!hit && !miss_done && !victim_valid, "R1", {29'd0, hit, miss_done, victim_valid}, 0);
      do_req(8'h00, "R1");
      chk(l_miss === 1'b1, "R1", 32'(l_miss), 1);
      chk(l_vv === 1'b0, "R1", 32'(l_vv), 0);
   endtask

   task automatic t_index();
      do_reset();
      do_req(8'h00, "R4");
      do_req(8'h10, "R4");            // same bank-0 set, bank-1 set 0
      chk(l_vv === 1'b0, "R4", 32'(l_vv), 0);
      do_req(8'h00, "R4");
      chk(l_hit === 1'b1, "R4", 32'(l_hit), 1);
      do_req(8'h10, "R4");
      chk(l_hit === 1'b1, "R4", 32'(l_hit), 1);
   endtask

   task automatic t_invalid();
      do_reset();
      do_req(8'h00, "R5");
      do_req(8'h04, "R5");            // bank-1 set 1 empty
      chk(l_vv === 1'b0, "R5", 32'(l_vv), 0);
      do_req(8'h00, "R5");
      chk(l_hit === 1'b1, "R5", 32'(l_hit), 1);
   endtask

   task automatic t_tie();
      do_reset();
      do_req(8'h00, "R8");            // both direct sets empty: bank 0 taken
      do_req(8'h04, "R8");
      do_req(8'h10, "R8");            // bank-1 set 0 still free only if 0x00 went to bank 0
      chk(l_vv === 1'b0, "R8", 32'(l_vv), 0);
   endtask

   task automatic t_reloc();
      do_reset();
      do_req(8'h00, "R6");            // bank0[0], ts0
      do_req(8'h10, "R6");            // bank1[0], ts1
      do_req(8'h04, "R6");            // bank1[1], ts2
      do_req(8'h00, "R9");            // hit, refresh to 3
      chk(l_hit === 1'b1, "R9", 32'(l_hit), 1);
      do_req(8'h14, "R7");            // oldest is 0x10 behind the move of 0x00
      chk(l_vv === 1'b1, "R7", 32'(l_vv), 1);
      chk(l_va === 8'h10, "R7", 32'(l_va), 32'h10);
      chk(l_va !== 8'h00, "R9", 32'(l_va), 0);
      do_req(8'h00, "R7");
      chk(l_hit === 1'b1, "R7", 32'(l_hit), 1);
      do_req(8'h14, "R7");
      chk(l_hit === 1'b1, "R7", 32'(l_hit), 1);
      do_req(8'h04, "R7");
      chk(l_hit === 1'b1, "R7", 32'(l_hit), 1);
   endtask

   task automatic t_idle();
      do_reset();
      do_req(8'h08, "R11");
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         req_addr = 8'(k * 37 + 5);
         chk(!hit && !miss_done && !victim_valid, "R11",
             {29'd0, hit, miss_done, victim_valid}, 0);
      end
      do_req(8'h08, "R11");
      chk(l_hit === 1'b1, "R11", 32'(l_hit), 1);
   endtask

   task automatic t_stream();
      logic [15:0] lf;
      do_reset();
      lf = 16'hACE1;
      for (int n = 0; n < 400; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         do_req({3'b000, lf[4:0]}, "R10");
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      model_clear();
      t_reset();
      t_index();
      t_invalid();
      t_tie();
      t_reloc();
      t_idle();
      t_stream();
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule